// File: doc/BRIEF.md
# Group Lock and Status Register Bank

This block is the control and status register slice of a save/restore controller. It keeps, for every descriptor group, an owning requester domain, three sticky protection bits and a group configuration field. It filters every access on a simple register bus (valid, write, address, data, requester domain) against those protection bits. The filtering takes effect as soon as the bits are set.

The same slice holds the controller's interrupt status. Five flags are raised by one-cycle event pulses from the executor and the sequencer. Four of them are cleared by writing ones, and the software-done flag is cleared when a new software request starts. An error-index field records which descriptor raised the first address or bus error. A global software reset bit clears the configuration and status state. It leaves the protection bits and owners alone, since only a hardware reset may release those. Descriptor execution, scheduling and descriptor storage live outside this block.

Top module: `grp_guard_csr`

## Requirements
- R1: After hardware reset, every group owner, protection bit and configuration field is zero, every status flag and the error index read as zero, and rsp_valid is low.
- R2: A permitted write to group register g (address 2+g) loads the configuration from bits [31:16]. It loads the owner from bits [DOM_W-1:0] unless that group's domain lock is already set. Protection bits 8 (domain), 9 (write) and 10 (read) are set by writing 1, and writing 0 leaves them unchanged. Other groups are untouched.
- R3: While a group's domain lock is set, a request whose domain differs from the group owner reads zero from that group's register. A write from such a domain is ignored and answered with rsp_err.
- R4: While a group's write lock is set, every write to that group's register is ignored and answered with rsp_err, whatever the requester domain.
- R5: While a group's read lock is set, every read of that group's register returns zero with rsp_err low, whatever the requester domain.
- R6: Each request accepted at a clock edge is answered by rsp_valid for the following cycle, with read data in rsp_rdata. rsp_err is high only for a blocked group write. A read of an unmapped address returns zero without error. A cycle without a request gives rsp_valid low.
- R7: The status register (address 1) shows the address error in bit 0, bus error in bit 1, software-done in bit 2, timeout in bit 3 and group conflict in bit 4. Each flag is set by its event pulse and is visible from the next cycle.
- R8: Writing ones to the status register clears bits 0, 1, 3 and 4. Bit 2 is not affected by such writes. Bit 2 is cleared by the software-start event.
- R9: An event pulse in the same cycle as a clear of its flag (write-one, software start or software reset) leaves the flag set.
- R10: The error index in status bits [16 +: ERR_IDX_W] is loaded from ev_err_idx on an address or bus error event, but only while neither the address nor the bus error flag is set. Otherwise it holds, and write-one clears do not change it.
- R11: Writing 1 to bit 0 of address 0 clears all group configuration fields, the status flags and the error index at that edge. It keeps all owners and protection bits. It raises soft_rst_o for the following cycle. Address 0 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| req_valid | input | 1 | Register request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (3) | Register address: 0 global, 1 status, 2+g group g |
| req_wdata | input | DATA_W (32) | Write data |
| req_dom | input | DOM_W (2) | Domain of the requester |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_err | output | 1 | Write was blocked by a protection bit |
| rsp_rdata | output | DATA_W (32) | Read data (zero for writes and blocked reads) |
| ev_addr_err | input | 1 | Address error event pulse |
| ev_bus_err | input | 1 | Bus error event pulse |
| ev_err_idx | input | ERR_IDX_W (10) | Descriptor index accompanying an error event |
| ev_sw_done | input | 1 | Software request completed pulse |
| ev_sw_start | input | 1 | Software request started pulse |
| ev_timeout | input | 1 | Group timeout event pulse |
| ev_conflict | input | 1 | Group conflict event pulse |
| grp_owner_o | output | NUM_GROUPS*DOM_W (8) | Owner domain per group, group g at [g*DOM_W +: DOM_W] |
| grp_lock_o | output | NUM_GROUPS*3 (12) | Protection bits per group: [3g] domain, [3g+1] write, [3g+2] read |
| grp_cfg_o | output | NUM_GROUPS*CFG_W (64) | Configuration field per group |
| soft_rst_o | output | 1 | One-cycle pulse after a software reset write |

## Verification
Two things can land on the same status flag in one cycle: an event pulse from the executor and a clear from the bus. The clear can be a write-one, a software start or a software reset. The bench drives the event and the clearing request in the same cycle, reads the status register afterwards and expects the flag still set. The error index stays at its first captured value. A second collision exists on the bus side: a write and the protection state that gates it. The bench sweeps every protection combination, owner and requester domain over every group. For each case it computes the expected read data, rsp_err and resulting owner and configuration outputs arithmetically.

// File: rtl/gg_csr_pkg.sv
package gg_csr_pkg;

  // Register addresses
  localparam int ADDR_GLOBAL = 0;
  localparam int ADDR_STATUS = 1;
  localparam int ADDR_GROUP0 = 2;

  // Group register field positions
  localparam int DLOCK_BIT = 8;
  localparam int WLOCK_BIT = 9;
  localparam int RLOCK_BIT = 10;
  localparam int CFG_LSB   = 16;

  // Status register field positions
  localparam int NUM_FLAGS  = 5;
  localparam int ST_ADDR    = 0;
  localparam int ST_BUS     = 1;
  localparam int ST_DONE    = 2;
  localparam int ST_TMO     = 3;
  localparam int ST_CONF    = 4;
  localparam int ERRIDX_LSB = 16;

  // Flags a write-one may clear (software-done excluded)
  localparam logic [NUM_FLAGS-1:0] W1C_MASK = 5'b11011;

  typedef struct packed {
    logic rd_lock;
    logic wr_lock;
    logic dom_lock;
  } lock_t;

endpackage

// File: rtl/gg_group_slot.sv
module gg_group_slot
  import gg_csr_pkg::*;
#(
  parameter int DOM_W  = 2,
  parameter int CFG_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              soft_clr,
  output logic [DOM_W-1:0]  owner_o,
  output lock_t             lock_o,
  output logic [CFG_W-1:0]  cfg_o
);

  logic [DOM_W-1:0] owner_q, owner_d;
  lock_t            lock_q, lock_d;
  logic [CFG_W-1:0] cfg_q, cfg_d;
  logic             upd;
  logic             unused_bits;

  assign unused_bits = ^wdata;

  always_comb begin
    owner_d = owner_q;
    lock_d  = lock_q;
    cfg_d   = cfg_q;
    if (soft_clr) cfg_d = '0;
    if (wr_en) begin
      lock_d.dom_lock = lock_q.dom_lock | wdata[DLOCK_BIT];
      lock_d.wr_lock  = lock_q.wr_lock  | wdata[WLOCK_BIT];
      lock_d.rd_lock  = lock_q.rd_lock  | wdata[RLOCK_BIT];
      if (!lock_q.dom_lock) owner_d = wdata[DOM_W-1:0];
      cfg_d = wdata[CFG_LSB +: CFG_W];
    end
  end

  assign upd = wr_en | soft_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= '0;
      lock_q  <= '0;
      cfg_q   <= '0;
    end else if (upd) begin
      owner_q <= owner_d;
      lock_q  <= lock_d;
      cfg_q   <= cfg_d;
    end
  end

  assign owner_o = owner_q;
  assign lock_o  = lock_q;
  assign cfg_o   = cfg_q;

  // R2
  sticky_dom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q.dom_lock |=> lock_q.dom_lock);
  // R2
  sticky_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q.wr_lock |=> lock_q.wr_lock);
  // R2
  sticky_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q.rd_lock |=> lock_q.rd_lock);
  // R2
  owner_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q.dom_lock |=> $stable(owner_q));
  // R4
  wr_locked_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q.wr_lock && !soft_clr) |=> $stable(cfg_q));

endmodule

// File: rtl/gg_status_bank.sv
module gg_status_bank
  import gg_csr_pkg::*;
#(
  parameter int ERR_IDX_W = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ev_addr_err,
  input  logic                 ev_bus_err,
  input  logic                 ev_sw_done,
  input  logic                 ev_sw_start,
  input  logic                 ev_timeout,
  input  logic                 ev_conflict,
  input  logic [ERR_IDX_W-1:0] ev_err_idx,
  input  logic                 w1c_en,
  input  logic [NUM_FLAGS-1:0] w1c_mask,
  input  logic                 soft_clr,
  output logic [NUM_FLAGS-1:0] flags_o,
  output logic [ERR_IDX_W-1:0] err_idx_o
);

  logic [NUM_FLAGS-1:0] flags_q, flags_d, ev_vec, clr_vec;
  logic [ERR_IDX_W-1:0] idx_q, idx_d;
  logic                 flags_en, idx_en, held, capture;

  always_comb begin
    ev_vec          = '0;
    ev_vec[ST_ADDR] = ev_addr_err;
    ev_vec[ST_BUS]  = ev_bus_err;
    ev_vec[ST_DONE] = ev_sw_done;
    ev_vec[ST_TMO]  = ev_timeout;
    ev_vec[ST_CONF] = ev_conflict;

    clr_vec = '0;
    if (w1c_en)      clr_vec = clr_vec | (w1c_mask & W1C_MASK);
    if (ev_sw_start) clr_vec[ST_DONE] = 1'b1;
    if (soft_clr)    clr_vec = '1;

    // events win over any clear of the same cycle
    flags_d  = (flags_q & ~clr_vec) | ev_vec;
    flags_en = (|ev_vec) | (|clr_vec);

    held    = soft_clr ? 1'b0 : (flags_q[ST_ADDR] | flags_q[ST_BUS]);
    capture = (ev_addr_err | ev_bus_err) & ~held;
    if (capture)       idx_d = ev_err_idx;
    else if (soft_clr) idx_d = '0;
    else               idx_d = idx_q;
    idx_en = capture | soft_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (flags_en) begin
      flags_q <= flags_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  assign flags_o   = flags_q;
  assign err_idx_o = idx_q;

  // R9
  addr_evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_addr_err |=> flags_q[ST_ADDR]);
  // R9
  tmo_evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_timeout |=> flags_q[ST_TMO]);
  // R8
  done_not_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q[ST_DONE] && !ev_sw_start && !soft_clr) |=> flags_q[ST_DONE]);
  // R10
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_q[ST_ADDR] || flags_q[ST_BUS]) && !soft_clr) |=> $stable(idx_q));

endmodule

// File: rtl/gg_access_gate.sv
module gg_access_gate
  import gg_csr_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int DOM_W      = 2,
  parameter int CFG_W      = 16,
  parameter int ERR_IDX_W  = 10,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 3
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 req_valid,
  input  logic                                 req_write,
  input  logic [ADDR_W-1:0]                    req_addr,
  input  logic [DATA_W-1:0]                    req_wdata,
  input  logic [DOM_W-1:0]                     req_dom,
  input  logic [NUM_GROUPS-1:0][DOM_W-1:0]     grp_owner,
  input  lock_t [NUM_GROUPS-1:0]               grp_lock,
  input  logic [NUM_GROUPS-1:0][CFG_W-1:0]     grp_cfg,
  input  logic [NUM_FLAGS-1:0]                 flags,
  input  logic [ERR_IDX_W-1:0]                 err_idx,
  output logic [NUM_GROUPS-1:0]                grp_wr_en,
  output logic                                 w1c_en,
  output logic                                 soft_req,
  output logic                                 rsp_valid,
  output logic                                 rsp_err,
  output logic [DATA_W-1:0]                    rsp_rdata,
  output logic                                 soft_rst_o
);

  localparam logic [ADDR_W-1:0] A_GLOBAL = ADDR_W'(ADDR_GLOBAL);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(ADDR_STATUS);

  logic [NUM_GROUPS-1:0]             sel, rd_blk, wr_blk;
  logic [NUM_GROUPS-1:0][DATA_W-1:0] grp_word;
  logic [DATA_W-1:0]                 status_word, rd_word, rdata_d;
  logic                              rd_blk_any, wr_blk_any;
  logic                              rsp_valid_q, rsp_err_q, soft_rst_q;
  logic [DATA_W-1:0]                 rsp_rdata_q;
  logic                              unused_wdata;

  assign unused_wdata = ^req_wdata[DATA_W-1:1];

  genvar g;
  generate
    for (g = 0; g < NUM_GROUPS; g++) begin : gen_grp
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(ADDR_GROUP0 + g);
      logic foreign;
      assign sel[g]       = req_valid && (req_addr == MY_ADDR);
      assign foreign      = grp_lock[g].dom_lock && (req_dom != grp_owner[g]);
      assign rd_blk[g]    = grp_lock[g].rd_lock | foreign;
      assign wr_blk[g]    = grp_lock[g].wr_lock | foreign;
      assign grp_wr_en[g] = sel[g] & req_write & ~wr_blk[g];
      always_comb begin
        grp_word[g]                      = '0;
        grp_word[g][DOM_W-1:0]           = grp_owner[g];
        grp_word[g][DLOCK_BIT]           = grp_lock[g].dom_lock;
        grp_word[g][WLOCK_BIT]           = grp_lock[g].wr_lock;
        grp_word[g][RLOCK_BIT]           = grp_lock[g].rd_lock;
        grp_word[g][CFG_LSB +: CFG_W]    = grp_cfg[g];
      end
    end
  endgenerate

  always_comb begin
    status_word                          = '0;
    status_word[NUM_FLAGS-1:0]           = flags;
    status_word[ERRIDX_LSB +: ERR_IDX_W] = err_idx;
  end

  assign w1c_en   = req_valid & req_write & (req_addr == A_STATUS);
  assign soft_req = req_valid & req_write & (req_addr == A_GLOBAL) & req_wdata[0];

  always_comb begin
    rd_word    = '0;
    rd_blk_any = 1'b0;
    wr_blk_any = 1'b0;
    if (req_valid && !req_write && (req_addr == A_STATUS)) rd_word = status_word;
    for (int k = 0; k < NUM_GROUPS; k++) begin
      if (sel[k]) begin
        if (req_write) begin
          wr_blk_any = wr_blk_any | wr_blk[k];
        end else if (rd_blk[k]) begin
          rd_blk_any = 1'b1;
        end else begin
          rd_word = grp_word[k];
        end
      end
    end
    rdata_d = req_write ? '0 : rd_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      soft_rst_q  <= 1'b0;
    end else begin
      rsp_valid_q <= req_valid;
      rsp_err_q   <= wr_blk_any;
      soft_rst_q  <= soft_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_rdata_q <= '0;
    end else if (req_valid) begin
      rsp_rdata_q <= rdata_d;
    end
  end

  assign rsp_valid  = rsp_valid_q;
  assign rsp_err    = rsp_err_q;
  assign rsp_rdata  = rsp_rdata_q;
  assign soft_rst_o = soft_rst_q;

  // R5
  blocked_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_blk_any |=> (rsp_rdata == '0) && !rsp_err);
  // R6
  err_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid);
  // R11
  soft_pulse_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |-> (rsp_valid && !rsp_err));
  // R2
  wr_en_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grp_wr_en));

endmodule

// File: rtl/grp_guard_csr.sv
module grp_guard_csr
  import gg_csr_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int DOM_W      = 2,
  parameter int CFG_W      = 16,
  parameter int ERR_IDX_W  = 10,
  parameter int DATA_W     = 32,
  localparam int ADDR_W    = $clog2(NUM_GROUPS + 2)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic                        req_write,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [DATA_W-1:0]           req_wdata,
  input  logic [DOM_W-1:0]            req_dom,
  output logic                        rsp_valid,
  output logic                        rsp_err,
  output logic [DATA_W-1:0]           rsp_rdata,
  input  logic                        ev_addr_err,
  input  logic                        ev_bus_err,
  input  logic [ERR_IDX_W-1:0]        ev_err_idx,
  input  logic                        ev_sw_done,
  input  logic                        ev_sw_start,
  input  logic                        ev_timeout,
  input  logic                        ev_conflict,
  output logic [NUM_GROUPS*DOM_W-1:0] grp_owner_o,
  output logic [NUM_GROUPS*3-1:0]     grp_lock_o,
  output logic [NUM_GROUPS*CFG_W-1:0] grp_cfg_o,
  output logic                        soft_rst_o
);

  logic [NUM_GROUPS-1:0][DOM_W-1:0] owner_w;
  lock_t [NUM_GROUPS-1:0]           lock_w;
  logic [NUM_GROUPS-1:0][CFG_W-1:0] cfg_w;
  logic [NUM_GROUPS-1:0]            grp_wr_en;
  logic [NUM_FLAGS-1:0]             flags;
  logic [ERR_IDX_W-1:0]             err_idx;
  logic                             w1c_en, soft_req;

  gg_access_gate #(
    .NUM_GROUPS(NUM_GROUPS), .DOM_W(DOM_W), .CFG_W(CFG_W),
    .ERR_IDX_W(ERR_IDX_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_gate (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_dom(req_dom),
    .grp_owner(owner_w), .grp_lock(lock_w), .grp_cfg(cfg_w),
    .flags(flags), .err_idx(err_idx),
    .grp_wr_en(grp_wr_en), .w1c_en(w1c_en), .soft_req(soft_req),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .soft_rst_o(soft_rst_o)
  );

  gg_status_bank #(.ERR_IDX_W(ERR_IDX_W)) u_status (
    .clk(clk), .rst_n(rst_n),
    .ev_addr_err(ev_addr_err), .ev_bus_err(ev_bus_err),
    .ev_sw_done(ev_sw_done), .ev_sw_start(ev_sw_start),
    .ev_timeout(ev_timeout), .ev_conflict(ev_conflict),
    .ev_err_idx(ev_err_idx),
    .w1c_en(w1c_en), .w1c_mask(req_wdata[NUM_FLAGS-1:0]),
    .soft_clr(soft_req),
    .flags_o(flags), .err_idx_o(err_idx)
  );

  genvar g;
  generate
    for (g = 0; g < NUM_GROUPS; g++) begin : gen_slot
      gg_group_slot #(.DOM_W(DOM_W), .CFG_W(CFG_W), .DATA_W(DATA_W)) u_slot (
        .clk(clk), .rst_n(rst_n),
        .wr_en(grp_wr_en[g]), .wdata(req_wdata), .soft_clr(soft_req),
        .owner_o(owner_w[g]), .lock_o(lock_w[g]), .cfg_o(cfg_w[g])
      );
      assign grp_owner_o[g*DOM_W +: DOM_W] = owner_w[g];
      assign grp_lock_o[3*g]               = lock_w[g].dom_lock;
      assign grp_lock_o[3*g+1]             = lock_w[g].wr_lock;
      assign grp_lock_o[3*g+2]             = lock_w[g].rd_lock;
      assign grp_cfg_o[g*CFG_W +: CFG_W]   = cfg_w[g];
    end
  endgenerate

endmodule

// File: tb/test_grp_guard_csr.sv
module test_grp_guard_csr;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [2:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [1:0]  req_dom = '0;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic        ev_addr_err = 1'b0, ev_bus_err = 1'b0, ev_sw_done = 1'b0;
  logic        ev_sw_start = 1'b0, ev_timeout = 1'b0, ev_conflict = 1'b0;
  logic [9:0]  ev_err_idx = '0;
  logic [7:0]  grp_owner_o;
  logic [11:0] grp_lock_o;
  logic [63:0] grp_cfg_o;
  logic        soft_rst_o;

  int checks = 0;
  int fails = 0;
  int cyc_cnt = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  grp_guard_csr i_grp_guard_csr (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_dom(req_dom),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .ev_addr_err(ev_addr_err), .ev_bus_err(ev_bus_err), .ev_err_idx(ev_err_idx),
    .ev_sw_done(ev_sw_done), .ev_sw_start(ev_sw_start),
    .ev_timeout(ev_timeout), .ev_conflict(ev_conflict),
    .grp_owner_o(grp_owner_o), .grp_lock_o(grp_lock_o), .grp_cfg_o(grp_cfg_o),
    .soft_rst_o(soft_rst_o)
  );

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt == 150000 && !finished) begin
      fails++;
      $display("FAIL R6 watchdog: act=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one request cycle; ev = {sw_start, conflict, timeout, sw_done, bus, addr}
  task automatic cyc(input logic v, input logic w, input logic [2:0] a, input logic [31:0] d,
                     input logic [1:0] dm, input logic [5:0] ev, input logic [9:0] ix);
    @(negedge clk);
    req_valid = v; req_write = w; req_addr = a; req_wdata = d; req_dom = dm;
    ev_addr_err = ev[0]; ev_bus_err = ev[1]; ev_sw_done = ev[2];
    ev_timeout = ev[3]; ev_conflict = ev[4]; ev_sw_start = ev[5]; ev_err_idx = ix;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    ev_addr_err = 1'b0; ev_bus_err = 1'b0; ev_sw_done = 1'b0;
    ev_timeout = 1'b0; ev_conflict = 1'b0; ev_sw_start = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic [1:0] dm);
    cyc(1'b1, 1'b1, a, d, dm, 6'd0, 10'd0);
  endtask

  task automatic rd(input logic [2:0] a, input logic [1:0] dm);
    cyc(1'b1, 1'b0, a, 32'd0, dm, 6'd0, 10'd0);
  endtask

  task automatic evp(input logic [5:0] ev, input logic [9:0] ix);
    cyc(1'b0, 1'b0, 3'd0, 32'd0, 2'd0, ev, ix);
  endtask

  initial begin
    logic [1:0]  m_owner;
    logic [15:0] m_cfg, cfg2;
    logic        dl, wl, rl, foreign, rblk, wblk;
    string       tag;

    // ---------------- reset state (R1)
    do_reset();
    @(negedge clk);
    chk("R1", "rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R1", "owners", {24'd0, grp_owner_o}, 32'd0);
    chk("R1", "locks", {20'd0, grp_lock_o}, 32'd0);
    chk("R1", "cfg lo", grp_cfg_o[31:0], 32'd0);
    chk("R1", "cfg hi", grp_cfg_o[63:32], 32'd0);
    rd(3'd1, 2'd0);
    chk("R1", "status", rsp_rdata, 32'd0);

    // ---------------- protection sweep (R2..R6)
    for (int g = 0; g < 4; g++) begin
      for (int lc = 0; lc < 8; lc++) begin
        for (int own = 0; own < 4; own++) begin
          do_reset();
          chk("R1", "locks after reset", {20'd0, grp_lock_o}, 32'd0);
          m_cfg   = 16'h0100 + 16'(g * 32 + lc * 4 + own);
          m_owner = 2'(own);
          dl = lc[0]; wl = lc[1]; rl = lc[2];
          wr(3'(2 + g), {m_cfg, 5'd0, 3'(lc), 6'd0, m_owner}, m_owner);
          chk("R2", "rsp_err on config", {31'd0, rsp_err}, 32'd0);
          chk("R2", "cfg loaded", {16'd0, grp_cfg_o[g*16 +: 16]}, {16'd0, m_cfg});
          chk("R2", "owner loaded", {30'd0, grp_owner_o[g*2 +: 2]}, {30'd0, m_owner});
          chk("R2", "locks set", {29'd0, grp_lock_o[g*3 +: 3]}, 32'(lc));
          for (int d = 0; d < 4; d++) begin
            foreign = dl && (2'(d) != m_owner);
            rblk = rl || foreign;
            wblk = wl || foreign;
            tag = rl ? "R5" : (foreign ? "R3" : "R6");
            rd(3'(2 + g), 2'(d));
            chk(tag, "read valid", {31'd0, rsp_valid}, 32'd1);
            chk(tag, "read err", {31'd0, rsp_err}, 32'd0);
            chk(tag, "read data", rsp_rdata,
                rblk ? 32'd0 : {m_cfg, 5'd0, 3'(lc), 6'd0, m_owner});
            cfg2 = 16'h1000 * 16'(d + 1) + 16'(g * 32 + lc * 4 + own);
            wr(3'(2 + g), {cfg2, 8'd0, 6'd0, 2'(d)}, 2'(d));
            tag = wl ? "R4" : (foreign ? "R3" : "R2");
            if (!wblk) begin
              m_cfg = cfg2;
              if (!dl) m_owner = 2'(d);
            end
            chk(tag, "write err", {31'd0, rsp_err}, {31'd0, wblk});
            chk(tag, "cfg after write", {16'd0, grp_cfg_o[g*16 +: 16]}, {16'd0, m_cfg});
            chk(tag, "owner after write", {30'd0, grp_owner_o[g*2 +: 2]}, {30'd0, m_owner});
            chk("R2", "locks sticky", {29'd0, grp_lock_o[g*3 +: 3]}, 32'(lc));
          end
          for (int o = 0; o < 4; o++) begin
            if (o != g) chk("R2", "other group cfg", {16'd0, grp_cfg_o[o*16 +: 16]}, 32'd0);
          end
        end
      end
    end

    // ---------------- unmapped / idle (R6)
    do_reset();
    rd(3'd7, 2'd1);
    chk("R6", "unmapped data", rsp_rdata, 32'd0);
    chk("R6", "unmapped err", {31'd0, rsp_err}, 32'd0);
    @(negedge clk);
    chk("R6", "idle valid", {31'd0, rsp_valid}, 32'd0);

    // ---------------- each flag (R7, R10)
    for (int k = 0; k < 5; k++) begin
      do_reset();
      evp(6'(1 << k), 10'(k + 3));
      rd(3'd1, 2'(k));
      chk("R7", "single flag", rsp_rdata[4:0], 32'(1 << k));
      chk("R10", "index on flag", {22'd0, rsp_rdata[25:16]}, (k < 2) ? 32'(k + 3) : 32'd0);
    end

    // ---------------- write-one mask sweep (R8)
    for (int m = 0; m < 32; m++) begin
      do_reset();
      evp(6'h1F, 10'd7);
      wr(3'd1, 32'(m), 2'd3);
      rd(3'd1, 2'd0);
      chk("R8", "w1c mask", {27'd0, rsp_rdata[4:0]}, 32'(5'h1F & ~(5'(m) & 5'h1B)));
      chk("R10", "index kept by w1c", {22'd0, rsp_rdata[25:16]}, 32'd7);
    end
    evp(6'h20, 10'd0);
    rd(3'd1, 2'd0);
    chk("R8", "sw start clears done", {31'd0, rsp_rdata[2]}, 32'd0);

    // ---------------- concurrency (R9)
    do_reset();
    evp(6'h01, 10'd2);
    cyc(1'b1, 1'b1, 3'd1, 32'h1F, 2'd0, 6'h01, 10'd4);
    rd(3'd1, 2'd0);
    chk("R9", "addr event vs w1c", {27'd0, rsp_rdata[4:0]}, 32'h01);
    chk("R10", "index held during error", {22'd0, rsp_rdata[25:16]}, 32'd2);
    evp(6'h24, 10'd0);
    rd(3'd1, 2'd0);
    chk("R9", "done vs sw start", {31'd0, rsp_rdata[2]}, 32'd1);
    cyc(1'b1, 1'b1, 3'd0, 32'd1, 2'd0, 6'h08, 10'd0);
    rd(3'd1, 2'd0);
    chk("R9", "timeout vs soft reset", rsp_rdata, 32'h08);

    // ---------------- error index capture (R10)
    do_reset();
    evp(6'h01, 10'd5);
    evp(6'h02, 10'd9);
    rd(3'd1, 2'd0);
    chk("R10", "first index kept", {22'd0, rsp_rdata[25:16]}, 32'd5);
    chk("R10", "both flags", {27'd0, rsp_rdata[4:0]}, 32'h03);
    wr(3'd1, 32'h03, 2'd0);
    evp(6'h02, 10'd12);
    rd(3'd1, 2'd0);
    chk("R10", "new index after clear", {22'd0, rsp_rdata[25:16]}, 32'd12);

    // ---------------- software reset (R11)
    do_reset();
    wr(3'd3, 32'hBEEF_0102, 2'd2);
    wr(3'd2, 32'h1234_0000, 2'd0);
    evp(6'h09, 10'd6);
    wr(3'd0, 32'd1, 2'd1);
    chk("R11", "soft pulse", {31'd0, soft_rst_o}, 32'd1);
    chk("R11", "cfg cleared lo", grp_cfg_o[31:0], 32'd0);
    chk("R11", "cfg cleared hi", grp_cfg_o[63:32], 32'd0);
    chk("R11", "owner kept", {30'd0, grp_owner_o[3:2]}, 32'd2);
    chk("R11", "lock kept", {29'd0, grp_lock_o[5:3]}, 32'd1);
    rd(3'd1, 2'd0);
    chk("R11", "pulse ended", {31'd0, soft_rst_o}, 32'd0);
    chk("R11", "status cleared", rsp_rdata, 32'd0);
    rd(3'd0, 2'd0);
    chk("R11", "global reads zero", rsp_rdata, 32'd0);
    rd(3'd3, 2'd0);
    chk("R11", "domain lock still blocks", rsp_rdata, 32'd0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule